// File: doc/BRIEF.md
# GPIO Edge Wake Event Logic

This block turns transitions on a bank of general-purpose pins into latched event flags. Each pin has a polarity input that picks the edge it watches: rising when the polarity input is 0, falling when it is 1. A watched edge on a pin that is configured as an input sets that pin's status flag. The flag stays set until the host writes a 1 to it.

Two request outputs summarise the flags:
- A power-management request asserts while any flagged pin is also enabled in a per-pin wake-enable register and a global enable bit is on.
- A system-management request uses its own per-pin enable register. Only the pins chosen by a build-time mask can drive it, and it has no global gate.

Pins configured as outputs never set a flag and never contribute to either request.

The host uses a small write port and a separate combinational read port. Both use a 2-bit register select:
- Select 0 is the status register. Writing a 1 to a bit clears that flag; writing 0 leaves it unchanged.
- Select 1 is the wake-enable register.
- Select 2 is the interrupt-enable register.
- Select 3 is the control register. Only bit 0 is used, and it is the global wake enable.

Pin levels are expected to be synchronised to the block clock already. The reset input is applied asynchronously and released through an internal two-stage synchroniser.

Top module: `gpio_wake_evt`

## Requirements
- R1: With a pin's polarity input at 0, a 0-to-1 change of its level between two clock samples sets that pin's status bit at the clock edge that sees the new level.
- R2: With a pin's polarity input at 1, a 1-to-0 change sets the status bit, and a 0-to-1 change leaves it unchanged.
- R3: After reset, the status, both enable registers and the control register read 0, and both requests are low. The first pin sample after reset release is taken only as the reference level and sets no status bit.
- R4: Writing select 0 clears every status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R5: If a watched edge and a write-1 clear reach the same status bit in the same cycle, the bit ends set.
- R6: The power-management request is high exactly when control bit 0 is 1 and at least one pin has its status bit set, its wake-enable bit set, and its direction input at 0 (input).
- R7: The system-management request is high exactly when at least one pin inside the build-time mask has its status bit set, its interrupt-enable bit set, and its direction input at 0. It does not depend on control bit 0.
- R8: A pin whose direction input is 1 (output) never sets its status bit. A bit already set on such a pin does not drive either request while the pin stays an output.
- R9: The wake-enable register reads back the last value written at select 1. The interrupt-enable register reads back the last value written at select 2, with bits outside the build-time mask always 0.
- R10: Control bit 0 reads back the last value written to bit 0 at select 3, and the upper bits of select 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_lvl | input | N_GPIO | Synchronised pin levels |
| pin_pol | input | N_GPIO | Per-pin edge select: 0 = rising, 1 = falling |
| pin_is_out | input | N_GPIO | Per-pin direction: 1 = output, excluded from events |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write register select |
| wr_data | input | N_GPIO | Host write data |
| rd_addr | input | 2 | Host read register select |
| rd_data | output | N_GPIO | Read data for the register chosen by rd_addr |
| pme_req | output | 1 | Power-management event request (level) |
| smi_req | output | 1 | System-management interrupt request (level) |

## Verification
Two cases are the hardest to reach from the ports, because each depends on two inputs meeting in one exact clock edge.

- **Edge and clear together (R5).** A pin edge and a host write-1 clear of the same bit must arrive in the same cycle. The stimulus task changes the pin level and raises the write strobe in the same time slot after a falling clock edge, so the rising edge sees both together.
- **Reference sample after reset (R3).** This case needs pins that are already high when reset is released. The bench holds non-zero levels through reset and release, then checks that no flag appears.

A long randomised phase then mixes direction changes, polarity flips and clears against the behavioural model on every clock.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned REG_AW       = 2;
  localparam int unsigned CTRL_GBL_BIT = 0;

  typedef enum logic [REG_AW-1:0] {
    SEL_STS    = 2'd0,
    SEL_WAKEEN = 2'd1,
    SEL_IRQEN  = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] pin_lvl,
  input  logic [N_GPIO-1:0] pin_pol,
  input  logic [N_GPIO-1:0] pin_is_out,
  output logic [N_GPIO-1:0] edge_hit
);
  logic [N_GPIO-1:0] prev_q, prev_d;
  logic              primed_q, primed_d;

  always_comb begin
    prev_d   = pin_lvl;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  for (genvar i = 0; i < N_GPIO; i++) begin : g_bit
    logic rise, fall, watched;
    assign rise    = pin_lvl[i] & ~prev_q[i];
    assign fall    = ~pin_lvl[i] & prev_q[i];
    assign watched = pin_pol[i] ? fall : rise;
    assign edge_hit[i] = primed_q & ~pin_is_out[i] & watched;
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int unsigned N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] edge_hit,
  input  logic              clr_en,
  input  logic [N_GPIO-1:0] clr_mask,
  output logic [N_GPIO-1:0] sts_q
);
  for (genvar i = 0; i < N_GPIO; i++) begin : g_bit
    logic clr, upd, nxt;
    always_comb begin
      clr = clr_en & clr_mask[i];
      upd = edge_hit[i] | clr;
      nxt = edge_hit[i] | (sts_q[i] & ~clr);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sts_q[i] <= 1'b0;
      else if (upd) sts_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/gpio_wake_regs.sv
module gpio_wake_regs
  import gpio_wake_pkg::*;
#(
  parameter int unsigned       N_GPIO   = 8,
  parameter logic [N_GPIO-1:0] SMI_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [N_GPIO-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [N_GPIO-1:0] sts_q,
  output logic              clr_en,
  output logic [N_GPIO-1:0] wake_en_q,
  output logic [N_GPIO-1:0] irq_en_q,
  output logic              gbl_en_q,
  output logic [N_GPIO-1:0] rd_data
);
  logic              wake_we, irq_we, ctrl_we;
  logic [N_GPIO-1:0] wake_en_d, irq_en_d;
  logic              gbl_en_d;

  always_comb begin
    clr_en    = wr_en && (reg_sel_e'(wr_addr) == SEL_STS);
    wake_we   = wr_en && (reg_sel_e'(wr_addr) == SEL_WAKEEN);
    irq_we    = wr_en && (reg_sel_e'(wr_addr) == SEL_IRQEN);
    ctrl_we   = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
    wake_en_d = wr_data;
    irq_en_d  = wr_data & SMI_MASK;
    gbl_en_d  = wr_data[CTRL_GBL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en_q <= '0;
      irq_en_q  <= '0;
      gbl_en_q  <= 1'b0;
    end else begin
      if (wake_we) wake_en_q <= wake_en_d;
      if (irq_we)  irq_en_q  <= irq_en_d;
      if (ctrl_we) gbl_en_q  <= gbl_en_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_addr))
      SEL_STS:    rd_data = sts_q;
      SEL_WAKEEN: rd_data = wake_en_q;
      SEL_IRQEN:  rd_data = irq_en_q;
      SEL_CTRL:   rd_data[CTRL_GBL_BIT] = gbl_en_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_evt_combine.sv
module gpio_evt_combine #(
  parameter int unsigned       N_GPIO   = 8,
  parameter logic [N_GPIO-1:0] SMI_MASK = 8'h0F
) (
  input  logic [N_GPIO-1:0] sts_q,
  input  logic [N_GPIO-1:0] wake_en_q,
  input  logic [N_GPIO-1:0] irq_en_q,
  input  logic              gbl_en_q,
  input  logic [N_GPIO-1:0] pin_is_out,
  output logic              pme_req,
  output logic              smi_req
);
  logic [N_GPIO-1:0] live;

  always_comb begin
    live    = sts_q & ~pin_is_out;
    pme_req = gbl_en_q & (|(live & wake_en_q));
    smi_req = |(live & irq_en_q & SMI_MASK);
  end
endmodule

// File: rtl/gpio_wake_evt.sv
module gpio_wake_evt
  import gpio_wake_pkg::*;
#(
  parameter int unsigned       N_GPIO     = 8,
  parameter logic [N_GPIO-1:0] SMI_MASK   = 8'h0F,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] pin_lvl,
  input  logic [N_GPIO-1:0] pin_pol,
  input  logic [N_GPIO-1:0] pin_is_out,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [N_GPIO-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [N_GPIO-1:0] rd_data,
  output logic              pme_req,
  output logic              smi_req
);
  logic              rst_sync_n;
  logic [N_GPIO-1:0] edge_hit;
  logic [N_GPIO-1:0] sts_q;
  logic [N_GPIO-1:0] wake_en_q, irq_en_q;
  logic              gbl_en_q;
  logic              clr_en;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  gpio_edge_det #(.N_GPIO(N_GPIO)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin_lvl(pin_lvl), .pin_pol(pin_pol),
    .pin_is_out(pin_is_out), .edge_hit(edge_hit)
  );

  gpio_evt_status #(.N_GPIO(N_GPIO)) u_sts (
    .clk(clk), .rst_n(rst_sync_n), .edge_hit(edge_hit), .clr_en(clr_en),
    .clr_mask(wr_data), .sts_q(sts_q)
  );

  gpio_wake_regs #(.N_GPIO(N_GPIO), .SMI_MASK(SMI_MASK)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sts_q(sts_q), .clr_en(clr_en),
    .wake_en_q(wake_en_q), .irq_en_q(irq_en_q), .gbl_en_q(gbl_en_q),
    .rd_data(rd_data)
  );

  gpio_evt_combine #(.N_GPIO(N_GPIO), .SMI_MASK(SMI_MASK)) u_comb (
    .sts_q(sts_q), .wake_en_q(wake_en_q), .irq_en_q(irq_en_q),
    .gbl_en_q(gbl_en_q), .pin_is_out(pin_is_out),
    .pme_req(pme_req), .smi_req(smi_req)
  );
endmodule

// File: rtl/gpio_wake_chk.sv
module gpio_wake_chk #(
  parameter int unsigned       N_GPIO   = 8,
  parameter logic [N_GPIO-1:0] SMI_MASK = 8'h0F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_GPIO-1:0] pin_is_out,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [N_GPIO-1:0] wr_data,
  input logic [N_GPIO-1:0] edge_hit,
  input logic [N_GPIO-1:0] sts_q,
  input logic [N_GPIO-1:0] irq_en_q,
  input logic              gbl_en_q,
  input logic              pme_req,
  input logic              smi_req
);
  // R1 R5
  edge_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(edge_hit)) == $past(edge_hit)));

  // R4
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R6
  pme_needs_gbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pme_req |-> gbl_en_q);

  // R7
  smi_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> ((sts_q & irq_en_q & SMI_MASK & ~pin_is_out) != '0));

  // R8
  out_pin_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sts_q & ~$past(sts_q)) & $past(pin_is_out)) == '0));
endmodule

bind gpio_wake_evt gpio_wake_chk #(.N_GPIO(N_GPIO), .SMI_MASK(SMI_MASK)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pin_is_out(pin_is_out), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .edge_hit(edge_hit), .sts_q(sts_q),
  .irq_en_q(irq_en_q), .gbl_en_q(gbl_en_q), .pme_req(pme_req), .smi_req(smi_req)
);

// File: tb/sim_gpio_wake_evt.sv
`timescale 1ns/1ps
module sim_gpio_wake_evt;
  localparam int unsigned N = 8;
  localparam logic [N-1:0] MASK = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [N-1:0] pin = '0, pol = '0, isout = '0, wd = '0;
  logic we = 1'b0;
  logic [1:0] wa = '0, ra = '0;
  logic [N-1:0] rd;
  logic pme, smi;

  always #2 clk = ~clk;

  gpio_wake_evt #(.N_GPIO(N), .SMI_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin), .pin_pol(pol), .pin_is_out(isout),
    .wr_en(we), .wr_addr(wa), .wr_data(wd), .rd_addr(ra), .rd_data(rd),
    .pme_req(pme), .smi_req(smi)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, started = 0;

  // behavioural reference
  bit [N-1:0] m_sts, m_prev, m_wake, m_irq;
  bit m_gbl, m_primed;
  int rel_cnt = 0;

  function automatic bit [N-1:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return m_sts;
      2'd1: return m_wake;
      2'd2: return m_irq;
      default: return {7'd0, m_gbl};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n || rel_cnt < 2) begin
      if (!rst_n) rel_cnt = 0; else rel_cnt++;
      m_sts = '0; m_prev = '0; m_wake = '0; m_irq = '0; m_gbl = 0; m_primed = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit e, c;
        e = m_primed && !isout[i] &&
            (pol[i] ? (!pin[i] && m_prev[i]) : (pin[i] && !m_prev[i]));
        c = we && wa == 2'd0 && wd[i];
        m_sts[i] = e || (m_sts[i] && !c);
      end
      m_prev = pin;
      if (we && wa == 2'd1) m_wake = wd;
      if (we && wa == 2'd2) m_irq = wd & MASK;
      if (we && wa == 2'd3) m_gbl = wd[0];
      m_primed = 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R6 R7: compared on every clock
  always @(negedge clk) begin
    if (started && !done) begin
      check("R6 pme_req", pme, m_gbl && ((m_sts & m_wake & ~isout) != 0));
      check("R7 smi_req", smi, (m_sts & m_irq & MASK & ~isout) != 0);
    end
  end

  task automatic step(input logic [N-1:0] p, input logic w, input logic [1:0] a,
                      input logic [N-1:0] d);
    @(negedge clk); #1;
    pin = p; we = w; wa = a; wd = d;
    @(negedge clk); #1;
    we = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    step(pin, 1'b1, a, d);
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag);
    @(negedge clk); #1;
    ra = a; #1;
    check(tag, rd, m_read(a));
  endtask

  task automatic rd_lit(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk); #1;
    ra = a; #1;
    check(tag, rd, exp);
  endtask

  initial begin
    #1 rst_n = 0;
    pin = 8'hA5;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    started = 1;
    repeat (6) @(negedge clk);
    // R3: reset state and no event from the pins already high
    rd_lit(2'd0, 8'h00, "R3 status after reset");
    rd_lit(2'd1, 8'h00, "R3 wake enable after reset");
    rd_lit(2'd2, 8'h00, "R3 irq enable after reset");
    rd_lit(2'd3, 8'h00, "R3 ctrl after reset");
    check("R3 pme low", pme, 0);
    check("R3 smi low", smi, 0);
    // R9 R10
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd_lit(2'd1, 8'hFF, "R9 wake enable readback");
    rd_lit(2'd2, 8'h0F, "R9 irq enable masked");
    rd_lit(2'd3, 8'h01, "R10 ctrl readback");
    // R1 rising edges
    step(8'h5A, 0, 2'd0, 8'h00);
    rd_lit(2'd0, 8'h5A, "R1 rising edges latch");
    // R4 write 0 keeps, write 1 clears
    wr(2'd0, 8'h00);
    rd_lit(2'd0, 8'h5A, "R4 write zero keeps");
    wr(2'd0, 8'h0A);
    rd_lit(2'd0, 8'h50, "R4 write one clears");
    wr(2'd0, 8'hFF);
    rd_lit(2'd0, 8'h00, "R4 clear all");
    // R2 falling polarity
    pol = 8'hFF;
    step(8'hA5, 0, 2'd0, 8'h00);
    rd_lit(2'd0, 8'h5A, "R2 falling edges latch, rising ignored");
    // R10 global gate
    wr(2'd3, 8'h00);
    check("R10 pme off without global", pme, 0);
    check("R7 smi independent of global", smi, 1);
    wr(2'd3, 8'h01);
    // R5 edge and clear together
    wr(2'd0, 8'hFF);
    step(8'h24, 1'b1, 2'd0, 8'hFF);
    rd_lit(2'd0, 8'h81, "R5 edge wins over clear");
    // R8 output pins
    wr(2'd0, 8'hFF);
    isout = 8'h0F;
    step(8'hFF, 0, 2'd0, 8'h00);
    step(8'h00, 0, 2'd0, 8'h00);
    rd_lit(2'd0, 8'hF0, "R8 output pins never set");
    isout = 8'hFF;
    #1 check("R8 set bits on outputs silent pme", pme, 0);
    check("R8 set bits on outputs silent smi", smi, 0);
    isout = 8'h00;
    // randomised phase against the model
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      pin = $urandom; we = ($urandom_range(0, 3) == 0); wa = $urandom; wd = $urandom;
      if ($urandom_range(0, 15) == 0) pol = $urandom;
      if ($urandom_range(0, 15) == 0) isout = $urandom;
      if (k % 50 == 0) begin
        ra = $urandom; #1;
        check("R9 R10 random readback", rd, m_read(ra));
      end
    end
    @(negedge clk); #1 we = 0;
    for (int a = 0; a < 4; a++) rd_chk(2'(a), "R4 final register compare");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule